// File: doc/BRIEF.md
# Load-Store Ordering Wait Predictor

This block tells the issue logic whether a load may run ahead of older stores whose addresses are not yet known. By default every load is allowed to go early. Sometimes a load reads memory before an older store to the same address, and the pipeline catches it. The violation logic then reports that load's PC. The block sets a wait bit for that PC. From then on, every lookup for that PC returns "wait", so the load holds until the older stores resolve.

The table is a plain array of single-bit entries. It is indexed by a slice of the load PC, and each port carries only that slice. An internal free-running counter wipes the whole table every `CLR_PERIOD` cycles. This lets loads that stopped conflicting go back to speculating. Detecting violations and flushing the pipeline are handled elsewhere.

Top module: `ld_order_predictor`

## Requirements
- R1: While reset is low, and after reset is released, every wait bit reads 0 and the clear counter restarts from zero.
- R2: A lookup for an index that has never been reported since the last clear returns `lk_wait` = 0, which means the load may speculate.
- R3: When `viol_valid` is high at a rising clock edge, the entry at `viol_idx` is 1 from the next cycle on.
- R4: Entries are independent. Setting one index changes no lookup of another index, including the end indices 0 and 2^IDX_W-1. The index is PC bits [IDX_LSB+IDX_W-1:IDX_LSB], which is bits [11:2] by default.
- R5: If a report and a lookup hit the same index in the same cycle, `lk_wait` is already 1 in that cycle, combinationally.
- R6: After reset is released, the CLR_PERIOD-th rising edge clears every entry, and so does every CLR_PERIOD-th edge after that (16384 by default).
- R7: A report arriving on the clearing edge wins for its own index: that entry is 1 after the edge, and all other entries are 0.
- R8: A set entry stays 1 on every edge that is not a clearing edge. Reporting an index that is already set leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_idx | input | IDX_W | Lookup PC bits [IDX_LSB+IDX_W-1:IDX_LSB] |
| lk_wait | output | 1 | 1: the load must wait for older stores; 0: it may speculate |
| viol_valid | input | 1 | An ordering violation is reported this cycle |
| viol_idx | input | IDX_W | PC bits of the offending load, same slice as `lk_idx` |

## Verification
The assertions check the following on every cycle: a report always leaves its entry set, same-cycle forwarding, no entry dropping outside a clearing edge, a clearing edge emptying the table apart from a coincident report, and the counter staying in range. Only the bench scenarios can show that the clear arrives at exactly the right edge counted from reset, and that reset leaves no entry set. They also show that a lookup at a different index, including the end indices, does not see a set entry.

// File: rtl/ld_order_predictor.sv
module ld_order_predictor #(
  parameter int IDX_LSB    = 2,
  parameter int IDX_W      = 10,
  parameter int CLR_PERIOD = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_wait,
  input  logic             viol_valid,
  input  logic [IDX_W-1:0] viol_idx
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(CLR_PERIOD + 1);

  logic [DEPTH-1:0] wbits;
  logic [CNT_W-1:0] cnt;
  logic             sweep;
  logic [DEPTH-1:0] set_mask;

  assign sweep    = (cnt == CNT_W'(CLR_PERIOD - 1));
  assign set_mask = viol_valid ? (DEPTH'(1) << viol_idx) : '0;
  assign lk_wait  = wbits[lk_idx] | (viol_valid & (viol_idx == lk_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbits <= '0;
      cnt   <= '0;
    end else begin
      cnt   <= sweep ? '0 : cnt + 1'b1;
      wbits <= (sweep ? '0 : wbits) | set_mask;
    end
  end
endmodule

module ld_order_predictor_chk #(
  parameter int IDX_W      = 10,
  parameter int CLR_PERIOD = 16384,
  parameter int CNT_W      = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic [IDX_W-1:0]    lk_idx,
  input logic                lk_wait,
  input logic                viol_valid,
  input logic [IDX_W-1:0]    viol_idx,
  input logic [(1<<IDX_W)-1:0] wbits,
  input logic [CNT_W-1:0]    cnt
);
  logic at_clear;
  assign at_clear = (cnt == CNT_W'(CLR_PERIOD - 1));

  a_r3_report_sets: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |=> wbits[$past(viol_idx)]);

  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_idx == lk_idx) |-> lk_wait);

  a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !at_clear |=> ((wbits & $past(wbits)) == $past(wbits)));

  a_r6_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (at_clear && !viol_valid) |=> (wbits == '0));

  a_r7_report_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (at_clear && viol_valid) |=> ($countones(wbits) == 1));

  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(CLR_PERIOD));
endmodule

bind ld_order_predictor ld_order_predictor_chk #(
  .IDX_W(IDX_W), .CLR_PERIOD(CLR_PERIOD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_wait(lk_wait),
  .viol_valid(viol_valid), .viol_idx(viol_idx), .wbits(wbits), .cnt(cnt)
);

// File: tb/ld_order_predictor_test.sv
module ld_order_predictor_test;
  localparam int T      = 10;
  localparam int IW     = 10;
  localparam int PERIOD = 16384;

  typedef struct packed {
    logic          vv;
    logic [IW-1:0] vi;
    logic [IW-1:0] li;
    logic          ex;
    logic [3:0]    rq;
  } vec_t;

  // rows applied one per cycle from a fresh reset; ex = lk_wait before the edge
  localparam vec_t VEC [11] = '{
    '{1'b0, 10'h000, 10'h040, 1'b0, 4'd2},  // R2 untouched
    '{1'b1, 10'h040, 10'h040, 1'b1, 4'd5},  // R5 forward
    '{1'b0, 10'h000, 10'h040, 1'b1, 4'd3},  // R3 set visible
    '{1'b0, 10'h000, 10'h041, 1'b0, 4'd4},  // R4 neighbour
    '{1'b0, 10'h000, 10'h03f, 1'b0, 4'd4},  // R4 neighbour below
    '{1'b1, 10'h080, 10'h040, 1'b1, 4'd8},  // R8 stays set
    '{1'b0, 10'h000, 10'h080, 1'b1, 4'd3},  // R3 second entry
    '{1'b1, 10'h3ff, 10'h000, 1'b0, 4'd4},  // R4 top end vs index 0
    '{1'b0, 10'h000, 10'h3ff, 1'b1, 4'd4},  // R4 top end set
    '{1'b1, 10'h040, 10'h040, 1'b1, 4'd8},  // R8 re-report
    '{1'b0, 10'h000, 10'h040, 1'b1, 4'd8}   // R8 still set
  };

  logic clk = 1'b0, rst_n = 1'b0, viol_valid = 1'b0, lk_wait;
  logic [IW-1:0] lk_idx = '0, viol_idx = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #(T/2) clk = ~clk;

  ld_order_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_wait(lk_wait),
    .viol_valid(viol_valid), .viol_idx(viol_idx)
  );

  task automatic tick();
    @(posedge clk);
    #(T/4);
  endtask

  task automatic check(input string rq, input logic [IW-1:0] idx, input logic exp);
    lk_idx = idx;
    #1;
    total++;
    if (lk_wait !== exp) begin
      bad++;
      $display("FAIL %s idx=%0h lk_wait=%0b expected=%0b", rq, idx, lk_wait, exp);
    end
  endtask

  task automatic do_reset();
    viol_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(T * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1", 10'h000, 1'b0);
    for (int i = 0; i < 11; i++) begin
      viol_valid = VEC[i].vv;
      viol_idx   = VEC[i].vi;
      check($sformatf("R%0d", VEC[i].rq), VEC[i].li, VEC[i].ex);
      tick();
    end
    viol_valid = 1'b0;

    // R1: reset wipes what the table learned
    do_reset();
    check("R1", 10'h040, 1'b0);
    check("R1", 10'h080, 1'b0);
    check("R1", 10'h3ff, 1'b0);

    // R6 / R7 timing: edges counted from reset release
    viol_valid = 1'b1; viol_idx = 10'h011;
    tick();                              // edge 1
    viol_valid = 1'b0;
    repeat (PERIOD - 2) tick();          // edges 2 .. PERIOD-1
    check("R8", 10'h011, 1'b1);
    tick();                              // edge PERIOD clears
    check("R6", 10'h011, 1'b0);
    viol_valid = 1'b1; viol_idx = 10'h011;
    tick();                              // edge PERIOD+1 sets again
    viol_valid = 1'b0;
    check("R3", 10'h011, 1'b1);
    repeat (PERIOD - 2) tick();          // up to edge 2*PERIOD-1
    check("R8", 10'h011, 1'b1);
    viol_valid = 1'b1; viol_idx = 10'h222;
    tick();                              // edge 2*PERIOD: clear plus report
    viol_valid = 1'b0;
    check("R7", 10'h222, 1'b1);
    check("R7", 10'h011, 1'b0);
    check("R6", 10'h3ff, 1'b0);
    finish_run();
  end
endmodule